// File: doc/BRIEF.md
# Fine-Step PWM Digital-to-Analog Generator

This block turns a stream of 12-bit unsigned samples into a pulse-width-modulated output whose duty fraction follows each sample. An external RC low-pass filter recovers the analog level. The output repeats with a fixed period of 32 clock counts. In each period the output is high for a whole number of counts, called the coarse width, and low for the rest.

Besides the coarse width, the block computes a micro-step count for each sample. A fine-delay edge-placement stage would use this count to shift the falling edge by a fraction of one clock. The micro-step count comes from the part of the period-times-sample product that the coarse width drops. That remainder is read as a 7-bit fraction of a clock and scaled by a programmable steps-per-clock value. The nominal scale is 111, about 150 ps per step. The scale is an input because the true step count drifts with temperature and supply voltage.

A sample is captured whenever its valid strobe is high. The capture takes effect only at the next period boundary, so every period is built from one consistent setting.

Top module: `fine_pwm_dac`

## Requirements
- R1: While reset is asserted, the PWM output is low, the coarse width and the micro-step outputs are 0, and the period-start strobe is low.
- R2: The period-start strobe is high for exactly one cycle in every 32. After reset is released, it first rises 32 cycles later, when the period counter wraps from 31 to 0.
- R3: The coarse width equals (32 × sample) / 4096, rounded down, which is sample bits 11..7.
- R4: Within a period, the PWM output is high for the first coarse-width cycles, starting at the period-start cycle, and low for the remaining cycles. The number of high cycles per period therefore equals the coarse width.
- R5: The micro-step output equals (fraction × scale) / 128, rounded down. The fraction is the remainder of (32 × sample) modulo 4096, divided by 32; this equals sample bits 6..0.
- R6: A sample captured during a period changes neither the coarse width, the micro-step output nor the PWM waveform until the next period-start cycle.
- R7: Bits 15..12 of the 16-bit sample word have no effect on any output.
- R8: The step scale is taken from the last cycle of a period. A scale change in the middle of a period leaves the micro-step output unchanged until the next period-start cycle.
- R9: If several valid strobes arrive in one period, the last one sets the next period. If none arrives, the previous setting repeats.
- R10: Code 0 gives a PWM output that never goes high. Code 4095 gives a coarse width of 31, so the output is low in the last cycle of every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one period count per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 16 | Sample word; the low 12 bits are the unsigned sample |
| sample_valid_i | input | 1 | Captures sample_i at the clock edge |
| step_scale_i | input | 8 | Micro-steps per clock cycle (nominally 111) |
| pwm_o | output | 1 | Pulse-width-modulated output |
| coarse_o | output | 5 | Coarse width, in clock counts, of the current period |
| micro_o | output | 8 | Micro-step count of the current period |
| period_start_o | output | 1 | High during the first cycle of each period |

## Verification
A sample or scale change becomes visible on coarse_o and micro_o in the period-start cycle that follows the next counter wrap. The bench applies each stimulus, waits for the strobe, and reads both values at the falling edge of that cycle. The PWM high count is then taken from exactly 32 falling-edge samples, starting with the start cycle, so the count covers one whole period. The hold checks for a sample or scale change made in the middle of a period read the outputs at the falling edge of cycle 31, one edge before the new setting may appear. The reset-release spacing is counted in falling edges from the release, where the first strobe is due on the 32nd.

// File: rtl/fpdac_pkg.sv
`timescale 1ns/1ps
package fpdac_pkg;
    // Default geometry of the generator
    localparam int DEF_WORD_W      = 16;  // bus word carrying a sample
    localparam int DEF_SAMPLE_W    = 12;  // unsigned sample width
    localparam int DEF_PERIOD_LOG2 = 5;   // period = 2**DEF_PERIOD_LOG2 counts
    localparam int DEF_SCALE_W     = 8;   // micro-step scale width
endpackage

// File: rtl/fpdac_period_counter.sv
`timescale 1ns/1ps
module fpdac_period_counter #(
    parameter int PERIOD_LOG2 = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [PERIOD_LOG2-1:0] cnt_o,
    output logic                   wrap_o
);
    logic [PERIOD_LOG2-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;   // power-of-two period wraps naturally
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == '1);
endmodule

// File: rtl/fpdac_width_calc.sv
`timescale 1ns/1ps
module fpdac_width_calc #(
    parameter int SAMPLE_W    = 12,
    parameter int PERIOD_LOG2 = 5,
    parameter int SCALE_W     = 8
) (
    input  logic [SAMPLE_W-1:0]    sample_i,
    input  logic [SCALE_W-1:0]     scale_i,
    output logic [PERIOD_LOG2-1:0] coarse_o,
    output logic [SCALE_W-1:0]     micro_o
);
    // Fraction bits left below the coarse count, read as a fraction of a clock
    localparam int FRAC_W = SAMPLE_W - PERIOD_LOG2;
    localparam int MP_W   = FRAC_W + SCALE_W;

    logic [FRAC_W-1:0] frac;
    logic [MP_W-1:0]   micro_prod;

    // Period is a power of two: (period * sample) >> SAMPLE_W is the top slice
    assign coarse_o   = sample_i[SAMPLE_W-1 -: PERIOD_LOG2];
    assign frac       = sample_i[FRAC_W-1:0];
    assign micro_prod = MP_W'(frac) * MP_W'(scale_i);
    // fraction < 1, so the scaled result is below scale and fits SCALE_W bits
    assign micro_o    = SCALE_W'(micro_prod >> FRAC_W);
endmodule

// File: rtl/fine_pwm_dac.sv
`timescale 1ns/1ps
module fine_pwm_dac
    import fpdac_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int SAMPLE_W    = DEF_SAMPLE_W,
    parameter int PERIOD_LOG2 = DEF_PERIOD_LOG2,
    parameter int SCALE_W     = DEF_SCALE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WORD_W-1:0]      sample_i,
    input  logic                   sample_valid_i,
    input  logic [SCALE_W-1:0]     step_scale_i,
    output logic                   pwm_o,
    output logic [PERIOD_LOG2-1:0] coarse_o,
    output logic [SCALE_W-1:0]     micro_o,
    output logic                   period_start_o
);
    typedef struct packed {
        logic [SAMPLE_W-1:0]    pend;    // last captured sample
        logic [PERIOD_LOG2-1:0] coarse;  // width applied to the current period
        logic [SCALE_W-1:0]     micro;   // micro-steps of the current period
        logic                   start;   // first cycle of a period
    } state_t;

    state_t st_d, st_q;

    logic [SAMPLE_W-1:0]    pend_next;
    logic [PERIOD_LOG2-1:0] cnt;
    logic                   wrap;
    logic [PERIOD_LOG2-1:0] calc_coarse;
    logic [SCALE_W-1:0]     calc_micro;

    // Only the low SAMPLE_W bits of the word carry the sample
    assign pend_next = sample_valid_i ? SAMPLE_W'(sample_i) : st_q.pend;

    fpdac_period_counter #(
        .PERIOD_LOG2(PERIOD_LOG2)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt),
        .wrap_o(wrap)
    );

    // Evaluated on the pending sample; its result is used only at the wrap
    fpdac_width_calc #(
        .SAMPLE_W   (SAMPLE_W),
        .PERIOD_LOG2(PERIOD_LOG2),
        .SCALE_W    (SCALE_W)
    ) u_calc (
        .sample_i(pend_next),
        .scale_i (step_scale_i),
        .coarse_o(calc_coarse),
        .micro_o (calc_micro)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pend  = pend_next;
        st_d.start = wrap;
        if (wrap) begin
            st_d.coarse = calc_coarse;
            st_d.micro  = calc_micro;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o          = (cnt < st_q.coarse);
    assign coarse_o       = st_q.coarse;
    assign micro_o        = st_q.micro;
    assign period_start_o = st_q.start;
endmodule

// File: rtl/fpdac_checker.sv
`timescale 1ns/1ps
module fpdac_checker #(
    parameter int PERIOD_LOG2 = 5,
    parameter int SCALE_W     = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pwm_o,
    input logic [PERIOD_LOG2-1:0] coarse_o,
    input logic [SCALE_W-1:0]     micro_o,
    input logic                   period_start_o
);
    // Independent position tracker, realigned by the observed strobe
    logic [PERIOD_LOG2-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = period_start_o ? PERIOD_LOG2'(1) : pos_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    AST_START_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |-> (pos_q == '0)); // R2
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |=> !period_start_o); // R2
    AST_PWM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_o == (pos_q < coarse_o)); // R4
    AST_COARSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start_o |-> $stable(coarse_o)); // R6
    AST_MICRO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start_o |-> $stable(micro_o)); // R8
    AST_LAST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == '1) |-> !pwm_o); // R10
endmodule

bind fine_pwm_dac fpdac_checker #(
    .PERIOD_LOG2(PERIOD_LOG2),
    .SCALE_W    (SCALE_W)
) u_fpdac_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_o         (pwm_o),
    .coarse_o      (coarse_o),
    .micro_o       (micro_o),
    .period_start_o(period_start_o)
);

// File: tb/test_fine_pwm_dac.sv
`timescale 1ns/1ps
module test_fine_pwm_dac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sample = '0;
    logic        valid = 1'b0;
    logic [7:0]  scale = 8'd111;
    logic        pwm;
    logic [4:0]  coarse;
    logic [7:0]  micro;
    logic        pstart;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    fine_pwm_dac i_fine_pwm_dac (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_i      (sample),
        .sample_valid_i(valid),
        .step_scale_i  (scale),
        .pwm_o         (pwm),
        .coarse_o      (coarse),
        .micro_o       (micro),
        .period_start_o(pstart)
    );

    // {sample word, scale, expected coarse, expected micro}
    localparam int NV = 8;
    localparam logic [39:0] VEC [NV] = '{
        {16'h0000, 8'd111, 8'd0,  8'd0  },  // R10 zero code
        {16'h0FFF, 8'd111, 8'd31, 8'd110},  // R10 full code
        {16'h0800, 8'd111, 8'd16, 8'd0  },
        {16'h0840, 8'd111, 8'd16, 8'd55 },
        {16'hF123, 8'd111, 8'd2,  8'd30 },  // R7 high nibble set
        {16'h07FF, 8'd255, 8'd15, 8'd253},
        {16'h0001, 8'd128, 8'd0,  8'd1  },
        {16'h0C3F, 8'd64,  8'd24, 8'd31 }
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Full-precision reference models
    function automatic int ref_coarse(input int s12);
        return (32 * s12) / 4096;
    endfunction
    function automatic int ref_micro(input int s12, input int sc);
        int rem;
        rem = (32 * s12) % 4096;
        return ((rem * 128 / 4096) * sc) / 128;
    endfunction

    task automatic apply(input logic [15:0] s, input logic [7:0] sc);
        sample = s;
        scale  = sc;
        valid  = 1'b1;
        @(negedge clk);
        valid  = 1'b0;
    endtask

    task automatic wait_start();
        int t = 0;
        while (!pstart) begin
            @(negedge clk);
            t++;
            if (t > 100) begin
                check("R2 strobe timeout", 0, 1);
                break;
            end
        end
    endtask

    // Called at the negedge of a start cycle; ends at the next one
    task automatic measure(input string req, input int exp_high);
        int high = 0;
        for (int i = 0; i < 32; i++) begin
            if (pwm) high++;
            @(negedge clk);
        end
        check(req, high, exp_high);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int t;
        // R1: reset state, with a sample offered during reset
        sample = 16'h0FFF;
        valid  = 1'b1;
        repeat (3) @(negedge clk);
        valid = 1'b0;
        check("R1 pwm", int'(pwm), 0);
        check("R1 coarse", int'(coarse), 0);
        check("R1 micro", int'(micro), 0);
        check("R1 start", int'(pstart), 0);
        rst_n = 1'b1;

        // R2: first strobe 32 cycles after release, then one every 32
        t = 0;
        do begin @(negedge clk); t++; end while (!pstart && t < 100);
        check("R2 first strobe delay", t, 32);
        t = 0;
        do begin @(negedge clk); t++; end while (!pstart && t < 100);
        check("R2 strobe spacing", t, 32);
        @(negedge clk);
        check("R2 strobe width", int'(pstart), 0);
        wait_start();

        // Table walk: R3, R5, R7, R10 values; R4 high count per period
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][39:24], VEC[v][23:16]);
            wait_start();
            check($sformatf("R3 R7 coarse vec %0d", v), int'(coarse), int'(VEC[v][15:8]));
            check($sformatf("R5 R7 micro vec %0d", v), int'(micro), int'(VEC[v][7:0]));
            measure($sformatf("R4 R10 high count vec %0d", v), int'(VEC[v][15:8]));
        end

        // Sweep against the full-precision reference (R3, R5, R4)
        for (int k = 0; k < 12; k++) begin
            int s  = (k * 347 + 5) % 4096;
            int sc = 60 + k * 17;
            apply(16'(s), 8'(sc));
            wait_start();
            check($sformatf("R3 sweep s=%0d", s), int'(coarse), ref_coarse(s));
            check($sformatf("R5 sweep s=%0d sc=%0d", s, sc), int'(micro), ref_micro(s, sc));
            measure($sformatf("R4 sweep s=%0d", s), ref_coarse(s));
        end

        // R6: setting 0x0800 (coarse 16), new sample 0x0400 mid-period
        apply(16'h0800, 8'd111);
        wait_start();
        begin
            int high = 0;
            apply(16'h0400, 8'd111);          // consumed cycle 0 (pwm high)
            for (int i = 1; i < 32; i++) begin
                if (pwm) high++;
                if (i == 31) check("R6 coarse held", int'(coarse), 16);
                @(negedge clk);
            end
            check("R6 waveform held", high + 1, 16);
        end
        check("R6 new coarse at start", int'(coarse), 8);
        check("R6 start seen", int'(pstart), 1);

        // R9: two samples in one period, last wins; then repeat with none
        apply(16'h0300, 8'd111);
        apply(16'h0A80, 8'd111);
        wait_start();
        check("R9 last sample wins", int'(coarse), 21);
        repeat (32) @(negedge clk);
        check("R9 start after idle", int'(pstart), 1);
        check("R9 setting repeats", int'(coarse), 21);
        measure("R9 repeated high count", 21);

        // R8: scale change mid-period (0x0840: frac 64)
        apply(16'h0840, 8'd111);
        wait_start();
        check("R8 micro before", int'(micro), 55);
        repeat (4) @(negedge clk);
        scale = 8'd200;
        repeat (27) @(negedge clk);           // cycle 31
        check("R8 micro held", int'(micro), 55);
        @(negedge clk);
        check("R8 micro after", int'(micro), 100);

        // R7: upper nibble alone differs, no effect
        apply(16'h5840, 8'd200);
        wait_start();
        check("R7 coarse", int'(coarse), 16);
        check("R7 micro", int'(micro), 100);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule